// File: doc/BRIEF.md
# Serial Port Status Flags and Grouped Interrupt Requests

This block keeps the ten status flags of a serial port and turns them into three interrupt request lines. The transmitter and the receiver feed it single-cycle event pulses: buffer empty or refilled, shift complete, character received with its noise, framing and parity qualifiers, idle line, receive-pin edge and break. Software sees the flags as one status word. It removes the receive-side flags by reading status and then reading data. The shifters, baud generation and the register file that carries the flags to a bus lie outside the block.

Three request lines group the flags. The transmit line covers buffer empty and shift complete. The receive line covers data full, idle, pin edge and break. The error line covers overrun, noise, framing and parity. Each flag has its own enable. A flag whose enable is off still shows in the status word, so software can poll it, but it raises no request. The requests are levels and stay asserted for as long as an enabled flag is set.

Top module: `serstat_irq_unit`

Status word bit positions: 0 transmit empty, 1 transmit complete, 2 receive full, 3 idle, 4 pin edge, 5 break, 6 overrun, 7 noise, 8 framing, 9 parity. The enable word uses the same positions.

## Requirements
- R1: After reset the status word reads 0x003: transmit empty and transmit complete are set and every other flag is clear.
- R2: Transmit empty, transmit complete, pin edge and break each have a set pulse and a clear pulse. A set pulse makes the flag 1 on the next cycle. A clear pulse alone makes it 0. When both arrive in the same cycle, the flag is 1.
- R3: A received character with receive full clear sets receive full. On the same edge, bits 7, 8 and 9 load that character's noise, framing and parity qualifiers.
- R4: A data read clears receive full only if an earlier status read saw receive full set and no data read came in between. A data read without that arming has no effect on the flag.
- R5: A character that completes while receive full is set and is not being cleared in that cycle sets overrun (bit 6). Receive full stays set and bits 7 to 9 keep their old values.
- R6: A character that completes in the same cycle as a clearing data read is taken as a new character. Receive full stays 1, bits 7 to 9 load the new qualifiers, and overrun is not set.
- R7: An idle-line pulse sets idle (bit 3). Idle clears through the status-then-data read sequence. Once cleared, idle-line pulses are ignored until a character sets receive full.
- R8: Overrun, noise, framing and parity clear through the same status-then-data read sequence, each one armed by a status read that saw it set.
- R9: The transmit request is the OR of enabled bits 0 and 1. The receive request is the OR of enabled bits 2 to 5. The error request is the OR of enabled bits 6 to 9. The enables never change the status word.
- R10: When a status read and a data read arrive in the same cycle, the data read acts only on arming from earlier status reads. The status read arms for the next data read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| txe_set_i | input | 1 | Transmit buffer became empty |
| txe_clr_i | input | 1 | Transmit buffer was written |
| txc_set_i | input | 1 | Transmitter went idle |
| txc_clr_i | input | 1 | Transmitter started shifting |
| rx_char_i | input | 1 | Receive shifter completed a character |
| rx_noise_i | input | 1 | Noise qualifier, valid with rx_char_i |
| rx_frame_i | input | 1 | Framing qualifier, valid with rx_char_i |
| rx_parity_i | input | 1 | Parity qualifier, valid with rx_char_i |
| rx_idle_i | input | 1 | Idle line detected |
| rx_edge_set_i | input | 1 | Active edge seen on the receive pin |
| rx_edge_clr_i | input | 1 | Clear the pin edge flag |
| rx_brk_set_i | input | 1 | Break detected |
| rx_brk_clr_i | input | 1 | Clear the break flag |
| stat_rd_i | input | 1 | Status word read strobe |
| data_rd_i | input | 1 | Data register read strobe |
| irq_en_i | input | 10 | Per-flag request enables |
| flags_o | output | 10 | Status word |
| irq_tx_o | output | 1 | Transmit request |
| irq_rx_o | output | 1 | Receive request |
| irq_err_o | output | 1 | Error request |

## Verification
Some properties hold on every cycle, and the assertions check those. Set pulses always win over clears on the pulse-driven flags. A character always leaves receive full set. An overrun keeps the error qualifiers frozen. A blocked idle flag stays low. An enabled set flag always raises its group's request. Other behaviour depends on the order of events over several cycles, and only the bench's scenarios can show it. That covers arming a clear with a status read, a data read that was never armed, a character that lands in the same cycle as a clearing read, and idle becoming available again only after a new character.

// File: rtl/serstat_pkg.sv
`timescale 1ns/1ps
package serstat_pkg;
  localparam int NUM_FLAGS = 10;
  localparam int NUM_GRP   = 3;
  localparam int SEQ_W     = 6;
  localparam int QUAL_W    = 3;
  localparam int EVT_N     = 4;

  // status word positions
  localparam int F_TXE = 0;
  localparam int F_TXC = 1;
  localparam int F_RXF = 2;
  localparam int F_IDL = 3;
  localparam int F_EDG = 4;
  localparam int F_BRK = 5;
  localparam int F_OVR = 6;
  localparam int F_NOI = 7;
  localparam int F_FRM = 8;
  localparam int F_PAR = 9;

  // positions inside the read-sequence cleared vector
  localparam int S_RXF = 0;
  localparam int S_IDL = 1;
  localparam int S_OVR = 2;
  localparam int S_ERR = 3;  // three qualifier flags follow

  localparam int G_TX  = 0;
  localparam int G_RX  = 1;
  localparam int G_ERR = 2;

  function automatic logic [NUM_FLAGS-1:0] grp_mask(input int g);
    logic [NUM_FLAGS-1:0] m;
    m = '0;
    case (g)
      G_TX:    begin m[F_TXE] = 1'b1; m[F_TXC] = 1'b1; end
      G_RX:    begin m[F_RXF] = 1'b1; m[F_IDL] = 1'b1; m[F_EDG] = 1'b1; m[F_BRK] = 1'b1; end
      default: begin m[F_OVR] = 1'b1; m[F_NOI] = 1'b1; m[F_FRM] = 1'b1; m[F_PAR] = 1'b1; end
    endcase
    return m;
  endfunction

  // status word position of each pulse-driven flag
  function automatic int evt_pos(input int i);
    case (i)
      0:       return F_TXE;
      1:       return F_TXC;
      2:       return F_EDG;
      default: return F_BRK;
    endcase
  endfunction
endpackage

// File: rtl/serstat_evt_bit.sv
`timescale 1ns/1ps
module serstat_evt_bit #(
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic clr_i,
  output logic q_o
);
  logic q_d, q_q;

  always_comb begin
    q_d = q_q;
    if (set_i)      q_d = 1'b1;
    else if (clr_i) q_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q_q <= RST_VAL;
    else        q_q <= q_d;
  end

  assign q_o = q_q;

  // R2
  set_wins_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> q_o);
  // R2
  clr_only_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i && !set_i) |=> !q_o);
endmodule

// File: rtl/serstat_clr_seq.sv
`timescale 1ns/1ps
module serstat_clr_seq #(
  parameter int W = 6
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] flags_i,
  input  logic         stat_rd_i,
  input  logic         data_rd_i,
  output logic [W-1:0] clr_o
);
  logic [W-1:0] arm_d, arm_q;

  // a status read snapshots the flags it saw; any data read consumes the arming
  always_comb begin
    arm_d = arm_q;
    if (stat_rd_i)      arm_d = flags_i;
    else if (data_rd_i) arm_d = '0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) arm_q <= '0;
    else        arm_q <= arm_d;
  end

  assign clr_o = data_rd_i ? arm_q : '0;

  // R10
  arm_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (data_rd_i && !stat_rd_i) |=> (clr_o == '0));
endmodule

// File: rtl/serstat_rx_core.sv
`timescale 1ns/1ps
module serstat_rx_core
  import serstat_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              char_i,
  input  logic [QUAL_W-1:0] qual_i,
  input  logic              idle_i,
  input  logic              stat_rd_i,
  input  logic              data_rd_i,
  output logic [SEQ_W-1:0]  seq_o
);
  logic              rxf_d, rxf_q;
  logic              idl_d, idl_q;
  logic              ovr_d, ovr_q;
  logic [QUAL_W-1:0] err_d, err_q;
  logic              allow_d, allow_q;
  logic [SEQ_W-1:0]  seq_q, clr;
  logic              accept, ovr_evt, idle_set;

  always_comb begin
    seq_q                        = '0;
    seq_q[S_RXF]                 = rxf_q;
    seq_q[S_IDL]                 = idl_q;
    seq_q[S_OVR]                 = ovr_q;
    seq_q[S_ERR +: QUAL_W]       = err_q;
  end

  serstat_clr_seq #(.W(SEQ_W)) u_seq (
    .clk       (clk),
    .rst_n     (rst_n),
    .flags_i   (seq_q),
    .stat_rd_i (stat_rd_i),
    .data_rd_i (data_rd_i),
    .clr_o     (clr)
  );

  always_comb begin
    accept   = char_i && (!rxf_q || clr[S_RXF]);
    ovr_evt  = char_i && rxf_q && !clr[S_RXF];
    idle_set = idle_i && allow_q;

    rxf_d = rxf_q;
    if (accept)          rxf_d = 1'b1;
    else if (clr[S_RXF]) rxf_d = 1'b0;

    ovr_d = ovr_q;
    if (ovr_evt)         ovr_d = 1'b1;
    else if (clr[S_OVR]) ovr_d = 1'b0;

    for (int i = 0; i < QUAL_W; i++) begin
      err_d[i] = err_q[i];
      if (accept)                err_d[i] = qual_i[i];
      else if (clr[S_ERR + i])   err_d[i] = 1'b0;
    end

    idl_d = idl_q;
    if (idle_set)        idl_d = 1'b1;
    else if (clr[S_IDL]) idl_d = 1'b0;

    allow_d = allow_q;
    if (accept)                         allow_d = 1'b1;
    else if (clr[S_IDL] && !idle_set)   allow_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rxf_q   <= 1'b0;
      idl_q   <= 1'b0;
      ovr_q   <= 1'b0;
      err_q   <= '0;
      allow_q <= 1'b1;
    end else begin
      rxf_q   <= rxf_d;
      idl_q   <= idl_d;
      ovr_q   <= ovr_d;
      err_q   <= err_d;
      allow_q <= allow_d;
    end
  end

  assign seq_o = seq_q;

  // R3
  rxf_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    char_i |=> rxf_q);
  // R4
  rxf_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rxf_q && !data_rd_i) |=> rxf_q);
  // R5
  ovr_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (char_i && rxf_q && !data_rd_i) |=> (ovr_q && rxf_q));
  // R5
  err_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (char_i && rxf_q && !data_rd_i) |=> $stable(err_q));
  // R7
  idle_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!allow_q && !idl_q) |=> !idl_q);
endmodule

// File: rtl/serstat_irq_group.sv
`timescale 1ns/1ps
module serstat_irq_group #(
  parameter int                NF   = 10,
  parameter logic [NF-1:0]     MASK = '0
) (
  input  logic [NF-1:0] flags_i,
  input  logic [NF-1:0] en_i,
  output logic          irq_o
);
  assign irq_o = |(flags_i & en_i & MASK);
endmodule

// File: rtl/serstat_irq_unit.sv
`timescale 1ns/1ps
module serstat_irq_unit
  import serstat_pkg::*;
(
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 txe_set_i,
  input  logic                 txe_clr_i,
  input  logic                 txc_set_i,
  input  logic                 txc_clr_i,
  input  logic                 rx_char_i,
  input  logic                 rx_noise_i,
  input  logic                 rx_frame_i,
  input  logic                 rx_parity_i,
  input  logic                 rx_idle_i,
  input  logic                 rx_edge_set_i,
  input  logic                 rx_edge_clr_i,
  input  logic                 rx_brk_set_i,
  input  logic                 rx_brk_clr_i,
  input  logic                 stat_rd_i,
  input  logic                 data_rd_i,
  input  logic [NUM_FLAGS-1:0] irq_en_i,
  output logic [NUM_FLAGS-1:0] flags_o,
  output logic                 irq_tx_o,
  output logic                 irq_rx_o,
  output logic                 irq_err_o
);
  logic                 rst_meta, rst_sync;
  logic [EVT_N-1:0]     evt_set, evt_clr, evt_q;
  logic [SEQ_W-1:0]     seq;
  logic [NUM_GRP-1:0]   irq;
  logic [NUM_FLAGS-1:0] flags;

  // assert asynchronously, release on the clock
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta <= 1'b0;
      rst_sync <= 1'b0;
    end else begin
      rst_meta <= 1'b1;
      rst_sync <= rst_meta;
    end
  end

  assign evt_set = {rx_brk_set_i, rx_edge_set_i, txc_set_i, txe_set_i};
  assign evt_clr = {rx_brk_clr_i, rx_edge_clr_i, txc_clr_i, txe_clr_i};

  for (genvar i = 0; i < EVT_N; i++) begin : g_evt
    serstat_evt_bit #(.RST_VAL(i < 2)) u_bit (
      .clk   (clk),
      .rst_n (rst_sync),
      .set_i (evt_set[i]),
      .clr_i (evt_clr[i]),
      .q_o   (evt_q[i])
    );
  end

  serstat_rx_core u_rx (
    .clk       (clk),
    .rst_n     (rst_sync),
    .char_i    (rx_char_i),
    .qual_i    ({rx_parity_i, rx_frame_i, rx_noise_i}),
    .idle_i    (rx_idle_i),
    .stat_rd_i (stat_rd_i),
    .data_rd_i (data_rd_i),
    .seq_o     (seq)
  );

  always_comb begin
    flags = '0;
    for (int i = 0; i < EVT_N; i++) flags[evt_pos(i)] = evt_q[i];
    flags[F_RXF] = seq[S_RXF];
    flags[F_IDL] = seq[S_IDL];
    flags[F_OVR] = seq[S_OVR];
    flags[F_NOI] = seq[S_ERR];
    flags[F_FRM] = seq[S_ERR + 1];
    flags[F_PAR] = seq[S_ERR + 2];
  end

  for (genvar g = 0; g < NUM_GRP; g++) begin : g_irq
    serstat_irq_group #(.NF(NUM_FLAGS), .MASK(grp_mask(g))) u_grp (
      .flags_i (flags),
      .en_i    (irq_en_i),
      .irq_o   (irq[g])
    );
  end

  assign flags_o   = flags;
  assign irq_tx_o  = irq[G_TX];
  assign irq_rx_o  = irq[G_RX];
  assign irq_err_o = irq[G_ERR];

  // R9
  irq_tx_cover_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    ((flags_o[F_TXE] && irq_en_i[F_TXE]) || (flags_o[F_TXC] && irq_en_i[F_TXC])) |-> irq_tx_o);
  // R9
  irq_err_quiet_chk: assert property (@(posedge clk) disable iff (!rst_sync)
    (irq_en_i[F_PAR:F_OVR] == '0) |-> !irq_err_o);
endmodule

// File: tb/serstat_irq_unit_tb.sv
`timescale 1ns/1ps
module serstat_irq_unit_tb;
  localparam int E_TXE_S = 0,  E_TXE_C = 1,  E_TXC_S = 2,  E_TXC_C = 3;
  localparam int E_CHAR  = 4,  E_NOI   = 5,  E_FRM   = 6,  E_PAR   = 7;
  localparam int E_IDLE  = 8,  E_EDG_S = 9,  E_EDG_C = 10, E_BRK_S = 11;
  localparam int E_BRK_C = 12, E_STAT  = 13, E_DATA  = 14;

  typedef struct {
    logic [9:0] flags;
    logic [2:0] irq;
    string      tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [14:0] ev = '0;
  logic [9:0]  en = '0;
  logic [9:0]  flags;
  logic        irq_tx, irq_rx, irq_err;
  exp_t        sb[$];
  int          n_vec = 0;
  int          n_bad = 0;
  bit          done = 1'b0;

  always #2 clk = ~clk;

  serstat_irq_unit u_dut (
    .clk(clk), .rst_n(rst_n),
    .txe_set_i(ev[E_TXE_S]), .txe_clr_i(ev[E_TXE_C]),
    .txc_set_i(ev[E_TXC_S]), .txc_clr_i(ev[E_TXC_C]),
    .rx_char_i(ev[E_CHAR]), .rx_noise_i(ev[E_NOI]),
    .rx_frame_i(ev[E_FRM]), .rx_parity_i(ev[E_PAR]),
    .rx_idle_i(ev[E_IDLE]),
    .rx_edge_set_i(ev[E_EDG_S]), .rx_edge_clr_i(ev[E_EDG_C]),
    .rx_brk_set_i(ev[E_BRK_S]), .rx_brk_clr_i(ev[E_BRK_C]),
    .stat_rd_i(ev[E_STAT]), .data_rd_i(ev[E_DATA]),
    .irq_en_i(en), .flags_o(flags),
    .irq_tx_o(irq_tx), .irq_rx_o(irq_rx), .irq_err_o(irq_err)
  );

  function automatic logic [14:0] e(input int p);
    logic [14:0] v;
    v = '0;
    v[p] = 1'b1;
    return v;
  endfunction

  // driver: apply one cycle of stimulus and queue what must follow the edge
  task automatic drive(input logic [14:0] evv, input logic [9:0] env,
                       input logic [9:0] ef, input logic [2:0] ei, input string tag);
    exp_t x;
    @(negedge clk);
    ev = evv;
    en = env;
    x.flags = ef;
    x.irq   = ei;
    x.tag   = tag;
    sb.push_back(x);
  endtask

  // monitor: sample after each rising edge, compare with the head of the queue
  initial begin
    forever begin
      @(posedge clk);
      #1;
      if (sb.size() > 0) begin
        exp_t x;
        x = sb.pop_front();
        n_vec++;
        if (flags !== x.flags || {irq_err, irq_rx, irq_tx} !== x.irq) begin
          n_bad++;
          $display("FAIL %s: flags=%h irq=%b expected flags=%h irq=%b",
                   x.tag, flags, {irq_err, irq_rx, irq_tx}, x.flags, x.irq);
        end
      end
    end
  end

  initial begin
    #(200000 * 4);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: run did not complete");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    drive('0, 10'h000, 10'h003, 3'b000, "R1 reset state");
    drive('0, 10'h003, 10'h003, 3'b001, "R9 tx request from enabled flags");
    drive(e(E_TXE_C), 10'h002, 10'h002, 3'b001, "R2 empty cleared");
    drive(e(E_TXC_C), 10'h002, 10'h000, 3'b000, "R2 complete cleared");
    drive(e(E_TXE_S) | e(E_TXE_C), 10'h002, 10'h001, 3'b000, "R2 set beats clear, R9 masked");
    drive(e(E_CHAR) | e(E_NOI) | e(E_PAR), 10'h000, 10'h285, 3'b000, "R3 char with qualifiers");
    drive(e(E_DATA), 10'h000, 10'h285, 3'b000, "R4 unarmed data read ignored");
    drive(e(E_CHAR) | e(E_FRM), 10'h3C0, 10'h2C5, 3'b100, "R5 overrun keeps errors");
    drive(e(E_STAT), 10'h000, 10'h2C5, 3'b000, "R4 status read arms");
    drive(e(E_DATA), 10'h000, 10'h001, 3'b000, "R4 R8 data read clears");
    drive(e(E_IDLE), 10'h008, 10'h009, 3'b010, "R7 idle sets");
    drive(e(E_STAT), 10'h000, 10'h009, 3'b000, "R7 status read");
    drive(e(E_DATA), 10'h000, 10'h001, 3'b000, "R7 idle cleared");
    drive(e(E_IDLE), 10'h000, 10'h001, 3'b000, "R7 idle blocked");
    drive(e(E_CHAR), 10'h000, 10'h005, 3'b000, "R3 clean char");
    drive(e(E_IDLE), 10'h000, 10'h00D, 3'b000, "R7 idle re-enabled");
    drive(e(E_STAT), 10'h000, 10'h00D, 3'b000, "R6 status read");
    drive(e(E_DATA) | e(E_CHAR) | e(E_FRM), 10'h000, 10'h105, 3'b000, "R6 char during clearing read");
    drive(e(E_STAT) | e(E_DATA), 10'h000, 10'h105, 3'b000, "R10 same-cycle reads no clear");
    drive(e(E_DATA), 10'h000, 10'h001, 3'b000, "R10 armed by same-cycle status");
    drive(e(E_STAT), 10'h000, 10'h001, 3'b000, "R4 status read with flag clear");
    drive(e(E_CHAR), 10'h000, 10'h005, 3'b000, "R3 char after early status");
    drive(e(E_DATA), 10'h000, 10'h005, 3'b000, "R4 stale arming ignored");
    drive(e(E_EDG_S) | e(E_BRK_S), 10'h030, 10'h035, 3'b010, "R2 edge and break set");
    drive(e(E_EDG_C), 10'h010, 10'h025, 3'b000, "R2 edge cleared");
    drive(e(E_BRK_C) | e(E_BRK_S), 10'h000, 10'h025, 3'b000, "R2 break set beats clear");
    drive(e(E_BRK_C), 10'h000, 10'h005, 3'b000, "R2 break cleared");
    drive(e(E_CHAR) | e(E_NOI), 10'h040, 10'h045, 3'b100, "R5 overrun discards noise");
    drive(e(E_STAT), 10'h000, 10'h045, 3'b000, "R8 status read");
    drive(e(E_DATA), 10'h000, 10'h001, 3'b000, "R8 overrun cleared");
    drive(e(E_TXC_S), 10'h3FF, 10'h003, 3'b001, "R9 all enabled");
    drive('0, 10'h000, 10'h003, 3'b000, "R9 enables off keep flags");

    @(negedge clk);
    ev = '0;
    en = '0;
    while (sb.size() > 0) @(negedge clk);
    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule